// File: doc/BRIEF.md
# Four-Level Address Translation Walker

This block converts a 64-bit virtual address into a 48-bit physical address by reading a tree of 8-byte descriptors from memory, with one 4KB-granule tree of up to four levels. A request carries the virtual address, the base address of the first table and the level (0 to 3) at which the walk starts. The walker fetches one descriptor per level through a read port with a request/response handshake. It follows table pointers downward until it reaches a 1GB block, a 2MB block or a 4KB page, or until it finds an illegal descriptor.

Each request receives one result: the physical address, a code for the size of the region that was hit, and a fault flag with the level at which the walk stopped. The upper sixteen bits of the virtual address must repeat one value. A virtual address that breaks this rule faults before any descriptor is read. A start level of 2 serves a virtual range of 1GB and skips the two upper tables.

Top module: `pt_walker`

## Requirements
- R1: `reqReady` is high only when no walk is in progress and no result is waiting. It falls in the cycle after a request is accepted and rises again in the cycle after `rspValid && rspReady`.
- R2: If bits [63:48] of the virtual address are neither all zero nor all one, the result is a fault at the start level, and no memory read is issued for that request.
- R3: Each read address equals the current table base plus eight times the 9-bit index of the current level. The index for level L is the virtual-address field with bits [47-9L : 39-9L]. The read address is held stable while `memReqValid` waits for `memReqReady`.
- R4: The first read uses `reqBase` and the index field of `reqStartLvl`. A walk that ends at level T makes exactly T - start + 1 reads.
- R5: At levels 0 to 2, descriptor bits [1:0] = 2'b11 are a table pointer. The next read then uses base {desc[47:12], 12'h000} and the next level's index. Bit 0 = 0 (2'b00 or 2'b10) is a fault at that level.
- R6: At level 0, bits [1:0] = 2'b01 are a fault at level 0.
- R7: At level 1, bits [1:0] = 2'b01 end the walk with physical address {desc[47:30], va[29:0]} and size code 2 (1GB).
- R8: At level 2, bits [1:0] = 2'b01 end the walk with physical address {desc[47:21], va[20:0]} and size code 1 (2MB).
- R9: At level 3, only bits [1:0] = 2'b11 are valid. They give physical address {desc[47:12], va[11:0]} and size code 0 (4KB). Any other value is a fault at level 3.
- R10: At most one read is outstanding. After a read is accepted, `memReqValid` stays low until its response has arrived.
- R11: The result is held stable while `rspValid` is high and `rspReady` is low. A fault result reports a physical address of zero and size code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Walker can accept a request |
| reqVa | input | 64 | Virtual address to translate |
| reqBase | input | 48 | Byte address of the first table |
| reqStartLvl | input | 2 | Level of the first table (0 to 3) |
| memReqValid | output | 1 | Descriptor read request |
| memReqReady | input | 1 | Memory accepts the read |
| memReqAddr | output | 48 | Byte address of the descriptor |
| memRspValid | input | 1 | Descriptor data present for one cycle |
| memRspData | input | 64 | Descriptor value |
| rspValid | output | 1 | Result present |
| rspReady | input | 1 | Result taken |
| rspPa | output | 48 | Physical address (zero on a fault) |
| rspSize | output | 2 | 0 = 4KB, 1 = 2MB, 2 = 1GB |
| rspFault | output | 1 | Walk ended in a fault |
| rspFaultLvl | output | 2 | Level at which the fault was found |

## Verification
The bench sweeps every start level against every level at which a walk can end. Each case uses several virtual addresses whose index fields and offsets differ, with both all-zero and all-one upper halves. These cases separate index selection per level, base chaining and the block-size split of the output address. Descriptors carry set attribute bits, and their address bits lie below the block boundary. This shows that only the right bits reach the result. Every illegal type encoding is placed at every level, and a missing table is included, so the fault level can be told apart from the start level. Upper-half patterns that differ in one bit from canonical check that the walker faults and issues no read.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [1:0] {
    KIND_FAULT = 2'd0,
    KIND_TABLE = 2'd1,
    KIND_BLOCK = 2'd2
  } descKind_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CHECK = 3'd1,
    ST_READ  = 3'd2,
    ST_WAIT  = 3'd3,
    ST_DONE  = 3'd4
  } walkState_e;

  typedef struct packed {
    logic load;      // latch a new request
    logic advance;   // follow a table pointer to the next level
    logic finBlock;  // record a translated address
    logic finFault;  // record a fault at the current level
  } walkStrobe_t;

endpackage

// File: rtl/pt_walker_ctrl.sv
module pt_walker_ctrl
  import pt_walker_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  output logic        memReqValid,
  input  logic        memReqReady,
  input  logic        memRspValid,
  output logic        rspValid,
  input  logic        rspReady,
  input  logic        canonOk,
  input  descKind_e   kind,
  output walkStrobe_t strb
);

  walkState_e stQ, stD;

  always_comb begin
    stD  = stQ;
    strb = '0;
    unique case (stQ)
      ST_IDLE: begin
        if (reqValid) begin
          strb.load = 1'b1;
          stD       = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (canonOk) begin
          stD = ST_READ;
        end else begin
          strb.finFault = 1'b1;
          stD           = ST_DONE;
        end
      end
      ST_READ: begin
        if (memReqReady) stD = ST_WAIT;
      end
      ST_WAIT: begin
        if (memRspValid) begin
          unique case (kind)
            KIND_TABLE: begin
              strb.advance = 1'b1;
              stD          = ST_READ;
            end
            KIND_BLOCK: begin
              strb.finBlock = 1'b1;
              stD           = ST_DONE;
            end
            default: begin
              strb.finFault = 1'b1;
              stD           = ST_DONE;
            end
          endcase
        end
      end
      ST_DONE: begin
        if (rspReady) stD = ST_IDLE;
      end
      default: stD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stQ <= ST_IDLE;
    else       stQ <= stD;
  end

  assign reqReady    = (stQ == ST_IDLE);
  assign memReqValid = (stQ == ST_READ);
  assign rspValid    = (stQ == ST_DONE);

  // R1: once a request is taken the walker is busy
  p_busy_after_accept_r1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R10: a single read in flight
  p_single_read_r10: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqReady) |=> !memReqValid);

  // R2: a non-canonical address goes straight to a result, no read
  p_canon_no_read_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stQ == ST_CHECK && !canonOk) |=> (rspValid && !memReqValid));

endmodule

// File: rtl/pt_walker_dp.sv
module pt_walker_dp
  import pt_walker_pkg::*;
#(
  parameter int VA_W   = 64,
  parameter int PA_W   = 48,
  parameter int DESC_W = 64,
  parameter int IDX_W  = 9,
  parameter int PAGE_W = 12,
  parameter int LVL_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobe_t       strb,
  input  logic [VA_W-1:0]   reqVa,
  input  logic [PA_W-1:0]   reqBase,
  input  logic [LVL_W-1:0]  reqStartLvl,
  input  logic [DESC_W-1:0] memRspData,
  output logic [PA_W-1:0]   memReqAddr,
  output logic              canonOk,
  output descKind_e         kind,
  output logic [PA_W-1:0]   rspPa,
  output logic [1:0]        rspSize,
  output logic              rspFault,
  output logic [LVL_W-1:0]  rspFaultLvl
);

  localparam int NUM_LVL  = 2 ** LVL_W;
  localparam int LAST_LVL = NUM_LVL - 1;
  localparam int HI_LSB   = PAGE_W + IDX_W * NUM_LVL;
  localparam int DESC_SH  = $clog2(DESC_W / 8);
  localparam int PAD_W    = PA_W - IDX_W - DESC_SH;

  logic [VA_W-1:0]  vaQ;
  logic [PA_W-1:0]  baseQ;
  logic [LVL_W-1:0] lvlQ;
  logic [PA_W-1:0]  paQ;
  logic [1:0]       sizeQ;
  logic             faultQ;
  logic [LVL_W-1:0] faultLvlQ;

  // per-level index fields and offset masks
  logic [IDX_W-1:0] idxAt  [NUM_LVL];
  logic [PA_W-1:0]  maskAt [NUM_LVL];

  for (genvar lv = 0; lv < NUM_LVL; lv++) begin : g_level
    localparam int FIELD_LSB = PAGE_W + IDX_W * (LAST_LVL - lv);
    assign idxAt[lv]  = vaQ[FIELD_LSB +: IDX_W];
    assign maskAt[lv] = {PA_W{1'b1}} >> (PA_W - FIELD_LSB);
  end

  logic [IDX_W-1:0] idxSel;
  logic [PA_W-1:0]  maskSel;
  logic [PA_W-1:0]  descAddr;
  logic [PA_W-1:0]  nextBase;
  logic [PA_W-1:0]  blockPa;
  logic [1:0]       descType;
  logic [1:0]       sizeCode;
  logic [VA_W-HI_LSB-1:0] vaHigh;
  logic [DESC_W-PA_W+PAGE_W-3:0] descUnused;

  assign idxSel     = idxAt[lvlQ];
  assign maskSel    = maskAt[lvlQ];
  assign memReqAddr = baseQ + {{PAD_W{1'b0}}, idxSel, {DESC_SH{1'b0}}};

  assign vaHigh  = vaQ[VA_W-1:HI_LSB];
  assign canonOk = (&vaHigh) | (~|vaHigh);

  assign descType   = memRspData[1:0];
  assign descAddr   = {memRspData[PA_W-1:PAGE_W], {PAGE_W{1'b0}}};
  assign nextBase   = descAddr;
  assign blockPa    = (descAddr & ~maskSel) | (vaQ[PA_W-1:0] & maskSel);
  assign sizeCode   = 2'(LAST_LVL) - 2'(lvlQ);
  assign descUnused = {memRspData[DESC_W-1:PA_W], memRspData[PAGE_W-1:2]};

  // level-dependent descriptor decoding
  always_comb begin
    if (lvlQ == LVL_W'(LAST_LVL)) begin
      kind = (descType == 2'b11) ? KIND_BLOCK : KIND_FAULT;
    end else if (!descType[0]) begin
      kind = KIND_FAULT;
    end else if (descType[1]) begin
      kind = KIND_TABLE;
    end else if (lvlQ == '0) begin
      kind = KIND_FAULT;
    end else begin
      kind = KIND_BLOCK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaQ       <= '0;
      baseQ     <= '0;
      lvlQ      <= '0;
      paQ       <= '0;
      sizeQ     <= '0;
      faultQ    <= 1'b0;
      faultLvlQ <= '0;
    end else if (strb.load) begin
      vaQ       <= reqVa;
      baseQ     <= reqBase;
      lvlQ      <= reqStartLvl;
      paQ       <= '0;
      sizeQ     <= '0;
      faultQ    <= 1'b0;
      faultLvlQ <= '0;
    end else if (strb.advance) begin
      baseQ <= nextBase;
      lvlQ  <= lvlQ + 1'b1;
    end else if (strb.finBlock) begin
      paQ    <= blockPa;
      sizeQ  <= sizeCode;
      faultQ <= 1'b0;
    end else if (strb.finFault) begin
      paQ       <= '0;
      sizeQ     <= '0;
      faultQ    <= 1'b1;
      faultLvlQ <= lvlQ;
    end
  end

  assign rspPa       = paQ;
  assign rspSize     = sizeQ;
  assign rspFault    = faultQ;
  assign rspFaultLvl = faultLvlQ;

  // R6: a fault reports the level being walked and clears the address
  p_fault_level_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.finFault |=> (rspFault && rspPa == '0 && rspFaultLvl == $past(lvlQ)));

  // R7: a success never carries the fault flag
  p_block_clean_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.finBlock |=> (!rspFault && rspSize != 2'd3));

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int VA_W   = 64,
  parameter int PA_W   = 48,
  parameter int DESC_W = 64,
  parameter int IDX_W  = 9,
  parameter int PAGE_W = 12,
  parameter int LVL_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [VA_W-1:0]   reqVa,
  input  logic [PA_W-1:0]   reqBase,
  input  logic [LVL_W-1:0]  reqStartLvl,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [PA_W-1:0]   memReqAddr,
  input  logic              memRspValid,
  input  logic [DESC_W-1:0] memRspData,
  output logic              rspValid,
  input  logic              rspReady,
  output logic [PA_W-1:0]   rspPa,
  output logic [1:0]        rspSize,
  output logic              rspFault,
  output logic [LVL_W-1:0]  rspFaultLvl
);

  walkStrobe_t strb;
  logic        canonOk;
  descKind_e   kind;

  pt_walker_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqReady    (reqReady),
    .memReqValid (memReqValid),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .rspValid    (rspValid),
    .rspReady    (rspReady),
    .canonOk     (canonOk),
    .kind        (kind),
    .strb        (strb)
  );

  pt_walker_dp #(
    .VA_W   (VA_W),
    .PA_W   (PA_W),
    .DESC_W (DESC_W),
    .IDX_W  (IDX_W),
    .PAGE_W (PAGE_W),
    .LVL_W  (LVL_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .reqVa       (reqVa),
    .reqBase     (reqBase),
    .reqStartLvl (reqStartLvl),
    .memRspData  (memRspData),
    .memReqAddr  (memReqAddr),
    .canonOk     (canonOk),
    .kind        (kind),
    .rspPa       (rspPa),
    .rspSize     (rspSize),
    .rspFault    (rspFault),
    .rspFaultLvl (rspFaultLvl)
  );

  // R11: a pending result does not move
  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> (rspValid && $stable(rspPa) && $stable(rspSize)
                                 && $stable(rspFault) && $stable(rspFaultLvl)));

  // R3: a stalled read keeps its address
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr)));

endmodule

// File: tb/sim_pt_walker.sv
`timescale 1ns/1ps
module sim_pt_walker;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [63:0] reqVa = '0;
  logic [47:0] reqBase = '0;
  logic [1:0]  reqStartLvl = '0;
  logic        memReqValid;
  logic        memReqReady = 1'b0;
  logic [47:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [63:0] memRspData = '0;
  logic        rspValid;
  logic        rspReady = 1'b0;
  logic [47:0] rspPa;
  logic [1:0]  rspSize;
  logic        rspFault;
  logic [1:0]  rspFaultLvl;

  always #2.5 clk = ~clk;

  pt_walker u0 (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqVa(reqVa),
    .reqBase(reqBase), .reqStartLvl(reqStartLvl),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .rspValid(rspValid), .rspReady(rspReady), .rspPa(rspPa), .rspSize(rspSize),
    .rspFault(rspFault), .rspFaultLvl(rspFaultLvl)
  );

  int checkCnt = 0;
  int failCnt  = 0;

  logic [63:0] memQ [logic [47:0]];
  logic [47:0] readLog[$];
  logic [47:0] expAddr[$];

  task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model: ready stalls every third cycle, response one cycle later
  initial begin
    logic        pend = 1'b0;
    logic [47:0] pendAddr = '0;
    int          rdyCtr = 0;
    forever begin
      @(negedge clk);
      memRspValid = 1'b0;
      memReqReady = (rdyCtr % 3) != 2;
      rdyCtr++;
      if (pend) begin
        memRspValid = 1'b1;
        memRspData  = memQ.exists(pendAddr) ? memQ[pendAddr] : 64'h0;
        pend = 1'b0;
      end else if (rstN && memReqValid && memReqReady) begin
        pend     = 1'b1;
        pendAddr = memReqAddr;
        readLog.push_back(memReqAddr);
      end
    end
  end

  function automatic logic [8:0] idxOf(input logic [63:0] va, input int lvl);
    return va[39 - 9*lvl +: 9];
  endfunction

  function automatic logic [47:0] tblBase(input int lvl);
    return 48'h0000_0010_0000 * 48'(lvl + 1) + 48'h0000_0000_3000;
  endfunction

  function automatic logic [63:0] mkVa(input int k);
    logic [47:0] lo;
    lo = (48'h1234_5678_9ABC * 48'(k + 1)) ^ (48'h0F0F_F0F0_3C3C << k);
    return {(k % 2 == 1) ? 16'hFFFF : 16'h0000, lo};
  endfunction

  function automatic logic [47:0] mkFrame(input int k);
    return 48'h5A5A_C3C3_F000 ^ (48'(k) << 33) ^ 48'h0000_0ABC_D000;
  endfunction

  function automatic logic [63:0] leafDesc(input logic [47:0] frame, input logic [1:0] typ);
    return {12'hA50, 4'h0, frame[47:12], 10'h2A5, typ};
  endfunction

  // builds a chain of tables from level s down to level t, ending in term
  task automatic buildChain(input logic [63:0] va, input int s, input int t,
                            input logic [63:0] term);
    logic [47:0] base;
    logic [47:0] nxt;
    memQ.delete();
    expAddr.delete();
    base = tblBase(s);
    for (int lvl = s; lvl < t; lvl++) begin
      nxt = tblBase(lvl + 1);
      memQ[base + 48'(idxOf(va, lvl)) * 48'd8] = {16'h8000, nxt[47:12], 12'h003};
      expAddr.push_back(base + 48'(idxOf(va, lvl)) * 48'd8);
      base = nxt;
    end
    memQ[base + 48'(idxOf(va, t)) * 48'd8] = term;
    expAddr.push_back(base + 48'(idxOf(va, t)) * 48'd8);
  endtask

  task automatic runWalk(input logic [63:0] va, input int s, input logic expFault,
                         input logic [1:0] expLvl, input logic [47:0] expPa,
                         input logic [1:0] expSize, input string tag);
    logic [47:0] paSeen;
    readLog.delete();
    @(negedge clk);
    reqVa = va; reqBase = tblBase(s); reqStartLvl = 2'(s); reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    chk(reqReady == 1'b0, {tag, " R1 busy after accept"}, 64'(reqReady), 64'd0);
    while (!rspValid) @(negedge clk);
    chk(reqReady == 1'b0, {tag, " R1 busy while result waits"}, 64'(reqReady), 64'd0);
    chk(rspFault == expFault, {tag, " fault flag"}, 64'(rspFault), 64'(expFault));
    chk(rspPa == expPa, {tag, " physical address"}, 64'(rspPa), 64'(expPa));
    chk(rspSize == expSize, {tag, " size code"}, 64'(rspSize), 64'(expSize));
    if (expFault)
      chk(rspFaultLvl == expLvl, {tag, " fault level"}, 64'(rspFaultLvl), 64'(expLvl));
    paSeen = rspPa;
    @(negedge clk);
    chk(rspValid && rspPa == paSeen, {tag, " R11 result held"}, 64'(rspPa), 64'(paSeen));
    rspReady = 1'b1;
    @(negedge clk);
    rspReady = 1'b0;
    chk(!rspValid && reqReady, {tag, " R1 ready after take"}, 64'({rspValid, reqReady}), 64'b01);
    chk(readLog.size() == expAddr.size(), {tag, " R4 read count"},
        64'(readLog.size()), 64'(expAddr.size()));
    for (int i = 0; i < expAddr.size() && i < readLog.size(); i++)
      chk(readLog[i] == expAddr[i], {tag, " R3 read address"}, 64'(readLog[i]), 64'(expAddr[i]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end

  initial begin
    logic [63:0] va;
    logic [47:0] fr;
    logic [47:0] pa;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady && !rspValid && !memReqValid, "R1 reset state",
        64'({reqReady, rspValid, memReqValid}), 64'b100);

    // successful walks: every start level against every legal end level
    for (int k = 0; k < 6; k++) begin
      for (int s = 0; s < 4; s++) begin
        for (int t = s; t < 4; t++) begin
          if (t == 0) continue;
          va = mkVa(k);
          fr = mkFrame(k + t);
          buildChain(va, s, t, leafDesc(fr, (t == 3) ? 2'b11 : 2'b01));
          if (t == 1)      pa = {fr[47:30], va[29:0]};
          else if (t == 2) pa = {fr[47:21], va[20:0]};
          else             pa = {fr[47:12], va[11:0]};
          runWalk(va, s, 1'b0, 2'd0, pa, 2'(3 - t),
                  (t == 1) ? "R7 1GB block R5 R4" : (t == 2) ? "R8 2MB block R5 R4"
                                                  : "R9 4KB page R5 R4");
        end
      end
    end

    // block type at level 0 is illegal
    for (int k = 0; k < 2; k++) begin
      va = mkVa(k + 7);
      buildChain(va, 0, 0, leafDesc(mkFrame(k), 2'b01));
      runWalk(va, 0, 1'b1, 2'd0, 48'h0, 2'd0, "R6 level0 block");
    end

    // invalid encodings at each level
    for (int s = 0; s < 4; s++) begin
      for (int t = s; t < 4; t++) begin
        for (int typ = 0; typ < 3; typ++) begin
          if (t < 3 && typ == 1) continue;
          va = mkVa(s + t + typ);
          buildChain(va, s, t, leafDesc(mkFrame(t), 2'(typ)));
          runWalk(va, s, 1'b1, 2'(t), 48'h0, 2'd0,
                  (t == 3) ? "R9 level3 non-page" : "R5 invalid descriptor");
        end
      end
    end

    // empty table reads as zero: fault at start level
    va = mkVa(3);
    memQ.delete();
    expAddr.delete();
    expAddr.push_back(tblBase(2) + 48'(idxOf(va, 2)) * 48'd8);
    runWalk(va, 2, 1'b1, 2'd2, 48'h0, 2'd0, "R5 missing descriptor");

    // non-canonical upper halves: fault with no read
    for (int k = 0; k < 4; k++) begin
      logic [15:0] hi;
      hi = (k == 0) ? 16'h0001 : (k == 1) ? 16'h8000 : (k == 2) ? 16'hFFFE : 16'h7FFF;
      va = {hi, mkVa(k)[47:0]};
      memQ.delete();
      expAddr.delete();
      runWalk(va, k, 1'b1, 2'(k), 48'h0, 2'd0, "R2 non-canonical");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end

endmodule